// File: doc/BRIEF.md
# Hidden Timing-Register Window for a Two-Device ATA Channel

This block sits at the register front end of a parallel ATA channel that serves two drives. Its byte/word I/O slave port normally passes every access to the drive task-file, which signals it with a one-cycle strobe. A fixed access pattern swaps the same offsets over to a hidden bank of timing and control registers. While the bank is visible, software picks one of the two devices through a select bit and programs that device's read-cycle and write-cycle timing bytes. It also programs a channel-wide address-setup count, and can read back which bus clock the board is strapped for.

The programmed timing bytes have no effect at once. A dedicated commit code written to the control register copies both devices' timing sets onto the output ports. Each timing byte is then split into an active count and a recovery count, one pair per device and per direction, for the bus-cycle generator downstream. A second key value written while the window is open closes it again.

Top module: `tfw_window_ctrl`

## Requirements
- R1: After reset the window is closed, every active and recovery output is 4'hF, `addr_setup` is 0, and once the window is opened the control and miscellaneous registers read 0 and both timing bytes of both devices read 8'hFF.
- R2: The window opens only after two consecutive 16-bit reads (`io_word`=1) at offset 1 followed directly by a byte write (`io_word`=0) of 8'h03 at offset 2. A third consecutive word read at offset 1 keeps the sequence armed.
- R3: Any other access made during the opening sequence restarts detection from the beginning. This includes a byte read at offset 1, a word-width write at offset 2, or an access at any other offset. A following write of 8'h03 then leaves the window closed.
- R4: While the window is closed, every access raises `tf_strobe` in the same cycle, `io_rdata` reads 0, and no hidden register changes.
- R5: While the window is open, `tf_strobe` stays low. Offset 0 is the read timing byte, 1 the write timing byte, 3 control, 5 strap and 6 miscellaneous. Offsets 4 and 7 read 0, and reads place the byte on `io_rdata[7:0]` with the upper byte 0.
- R6: Bit 0 of the miscellaneous register selects device 0 or device 1. Reads and writes at offsets 0 and 1 reach only that device's timing set.
- R7: Bits 5:4 of the miscellaneous register are the shared address-setup count and drive `addr_setup`. All other miscellaneous bits except bit 0 read 0.
- R8: Bit 0 of the strap register reads `bus_clk_25` (1 = 25 MHz, 0 = 33 MHz). The other bits read 0, and writes to offset 5 have no effect.
- R9: A write of 8'h85 to control copies both devices' stored timing bytes to the outputs, visible after the write's clock edge. Any other control value is only stored and leaves the outputs unchanged.
- R10: For each committed timing byte, bits 7:4 drive the active-count output and bits 3:0 drive the recovery-count output of that device and direction, at bit slice [4*d+3:4*d] for device d.
- R11: A write with data 8'h83 at offset 2 while the window is open closes it. Other values written at offset 2 leave it open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_req | input | 1 | I/O access valid this cycle |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| io_addr | input | 3 | Register offset |
| io_wdata | input | 8 | Write data byte |
| bus_clk_25 | input | 1 | Board clock strap, 1 = 25 MHz |
| io_rdata | output | 16 | Read data, combinational with the request |
| tf_strobe | output | 1 | Access forwarded to the task-file |
| window_open | output | 1 | Hidden bank visible |
| addr_setup | output | 2 | Shared address-setup count |
| rd_active | output | 8 | Read active count, 4 bits per device |
| rd_recover | output | 8 | Read recovery count, 4 bits per device |
| wr_active | output | 8 | Write active count, 4 bits per device |
| wr_recover | output | 8 | Write recovery count, 4 bits per device |

## Verification
The bench sweeps timing bytes in steps of 15 over the full byte range for both device selects. Different values go to the read and write bytes, so a swapped direction, a swapped nibble or a wrong device slot each produce a distinct miscompare. Every commit is preceded by a non-commit control write, which separates a commit decoder from one that copies on any control write. The opening sequence is tried with an interrupting byte read, an interrupting write elsewhere, a word-width key write and an extra word read, which separates a detector that restarts correctly from one that only counts reads.

// File: rtl/tfw_pkg.sv
package tfw_pkg;
  localparam int unsigned OFS_RDTIM = 0;
  localparam int unsigned OFS_WRTIM = 1;
  localparam int unsigned OFS_KEY   = 2;
  localparam int unsigned OFS_CTRL  = 3;
  localparam int unsigned OFS_STRAP = 5;
  localparam int unsigned OFS_MISC  = 6;

  localparam logic [7:0] KEY_OPEN    = 8'h03;
  localparam logic [7:0] KEY_SHUT    = 8'h83;
  localparam logic [7:0] CTRL_COMMIT = 8'h85;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ONE  = 2'd1,
    SEQ_TWO  = 2'd2,
    SEQ_OPEN = 2'd3
  } seq_e;
endpackage

// File: rtl/tfw_seq.sv
module tfw_seq
  import tfw_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic              word,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              open
);
  seq_e cur_q, nxt;

  logic probe_rd, key_wr, shut_wr;
  assign probe_rd = !wr && word && (addr == ADDR_W'(OFS_WRTIM));
  assign key_wr   = wr && !word && (addr == ADDR_W'(OFS_KEY)) && (wdata == KEY_OPEN);
  assign shut_wr  = wr && (addr == ADDR_W'(OFS_KEY)) && (wdata == KEY_SHUT);

  always_comb begin
    nxt = cur_q;
    if (req) begin
      if (cur_q == SEQ_OPEN) begin
        if (shut_wr) nxt = SEQ_IDLE;
      end else if (probe_rd) begin
        nxt = (cur_q == SEQ_IDLE) ? SEQ_ONE : SEQ_TWO;
      end else if ((cur_q == SEQ_TWO) && key_wr) begin
        nxt = SEQ_OPEN;
      end else begin
        nxt = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= SEQ_IDLE;
    else        cur_q <= nxt;
  end

  assign open = (cur_q == SEQ_OPEN);

  // R2
  open_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(cur_q == SEQ_TWO && req && key_wr));

  // R3
  byte_probe_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!open && req && !wr && !word && addr == ADDR_W'(OFS_WRTIM)) |=> (cur_q == SEQ_IDLE));

  // R11
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open && req && shut_wr) |=> !open);
endmodule

// File: rtl/tfw_bank.sv
module tfw_bank
  import tfw_pkg::*;
#(
  parameter int unsigned NUM_DEV = 2,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned TIM_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          open,
  input  logic                          req,
  input  logic                          wr,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [7:0]                    wdata,
  input  logic                          strap,
  output logic [7:0]                    rdata,
  output logic [1:0]                    setup,
  output logic [NUM_DEV-1:0][TIM_W-1:0] rd_cm,
  output logic [NUM_DEV-1:0][TIM_W-1:0] wr_cm
);
  localparam int unsigned SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [7:0] MISC_MASK = 8'h30 | 8'((1 << SEL_W) - 1);
  localparam logic [TIM_W-1:0] SLOWEST = '1;

  logic [NUM_DEV-1:0][TIM_W-1:0] rd_q, rd_d, wr_q, wr_d, rd_cm_d, wr_cm_d;
  logic [7:0] ctrl_q, ctrl_d, misc_q, misc_d;
  logic [SEL_W-1:0] sel;
  logic wen, commit;

  assign sel    = misc_q[SEL_W-1:0];
  assign wen    = open && req && wr;
  assign commit = wen && (addr == ADDR_W'(OFS_CTRL)) && (wdata == CTRL_COMMIT);

  always_comb begin
    rd_d    = rd_q;
    wr_d    = wr_q;
    ctrl_d  = ctrl_q;
    misc_d  = misc_q;
    rd_cm_d = rd_cm;
    wr_cm_d = wr_cm;
    if (wen) begin
      case (addr)
        ADDR_W'(OFS_RDTIM): rd_d[sel] = TIM_W'(wdata);
        ADDR_W'(OFS_WRTIM): wr_d[sel] = TIM_W'(wdata);
        ADDR_W'(OFS_CTRL):  ctrl_d    = wdata;
        ADDR_W'(OFS_MISC):  misc_d    = wdata & MISC_MASK;
        default: ;
      endcase
    end
    if (commit) begin
      rd_cm_d = rd_q;
      wr_cm_d = wr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= {NUM_DEV{SLOWEST}};
      wr_q   <= {NUM_DEV{SLOWEST}};
      rd_cm  <= {NUM_DEV{SLOWEST}};
      wr_cm  <= {NUM_DEV{SLOWEST}};
      ctrl_q <= '0;
      misc_q <= '0;
    end else begin
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      rd_cm  <= rd_cm_d;
      wr_cm  <= wr_cm_d;
      ctrl_q <= ctrl_d;
      misc_q <= misc_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (open) begin
      case (addr)
        ADDR_W'(OFS_RDTIM): rdata = 8'(rd_q[sel]);
        ADDR_W'(OFS_WRTIM): rdata = 8'(wr_q[sel]);
        ADDR_W'(OFS_CTRL):  rdata = ctrl_q;
        ADDR_W'(OFS_STRAP): rdata = {7'd0, strap};
        ADDR_W'(OFS_MISC):  rdata = misc_q;
        default:            rdata = '0;
      endcase
    end
  end

  assign setup = misc_q[5:4];

  // R4
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !open |=> ($stable(rd_q) && $stable(wr_q) && $stable(ctrl_q) && $stable(misc_q)));

  // R9
  commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rd_cm) || !$stable(wr_cm)) |-> $past(commit));

  // R7
  misc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (misc_q & ~MISC_MASK) == 8'h00);
endmodule

// File: rtl/tfw_split.sv
module tfw_split #(
  parameter int unsigned TIM_W = 8,
  localparam int unsigned NIB_W = TIM_W / 2
) (
  input  logic [TIM_W-1:0] tim,
  output logic [NIB_W-1:0] act,
  output logic [NIB_W-1:0] rec
);
  assign act = tim[TIM_W-1:NIB_W];
  assign rec = tim[NIB_W-1:0];
endmodule

// File: rtl/tfw_window_ctrl.sv
module tfw_window_ctrl
  import tfw_pkg::*;
#(
  parameter int unsigned NUM_DEV = 2,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned RD_W    = 16,
  parameter int unsigned TIM_W   = 8,
  localparam int unsigned NIB_W  = TIM_W / 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     io_req,
  input  logic                     io_wr,
  input  logic                     io_word,
  input  logic [ADDR_W-1:0]        io_addr,
  input  logic [7:0]               io_wdata,
  input  logic                     bus_clk_25,
  output logic [RD_W-1:0]          io_rdata,
  output logic                     tf_strobe,
  output logic                     window_open,
  output logic [1:0]               addr_setup,
  output logic [NUM_DEV*NIB_W-1:0] rd_active,
  output logic [NUM_DEV*NIB_W-1:0] rd_recover,
  output logic [NUM_DEV*NIB_W-1:0] wr_active,
  output logic [NUM_DEV*NIB_W-1:0] wr_recover
);
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic open;
  logic [7:0] bank_rdata;
  logic [NUM_DEV-1:0][TIM_W-1:0] rd_cm, wr_cm;

  tfw_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_q), .req(io_req), .wr(io_wr), .word(io_word),
    .addr(io_addr), .wdata(io_wdata), .open(open)
  );

  tfw_bank #(.NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W), .TIM_W(TIM_W)) u_bank (
    .clk(clk), .rst_n(rst_sync_q), .open(open), .req(io_req), .wr(io_wr),
    .addr(io_addr), .wdata(io_wdata), .strap(bus_clk_25), .rdata(bank_rdata),
    .setup(addr_setup), .rd_cm(rd_cm), .wr_cm(wr_cm)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    tfw_split #(.TIM_W(TIM_W)) u_rd (
      .tim(rd_cm[d]), .act(rd_active[d*NIB_W +: NIB_W]), .rec(rd_recover[d*NIB_W +: NIB_W])
    );
    tfw_split #(.TIM_W(TIM_W)) u_wr (
      .tim(wr_cm[d]), .act(wr_active[d*NIB_W +: NIB_W]), .rec(wr_recover[d*NIB_W +: NIB_W])
    );
  end

  assign io_rdata    = RD_W'(bank_rdata);
  assign tf_strobe   = io_req && !open;
  assign window_open = open;

  // R5
  open_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    window_open |-> !tf_strobe);

  // R4
  locked_rdata_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    tf_strobe |-> (io_rdata == '0));
endmodule

// File: tb/tfw_window_ctrl_test.sv
module tfw_window_ctrl_test;
  logic clk = 1'b0;
  logic rst_n, io_req, io_wr, io_word, bus_clk_25;
  logic [2:0] io_addr;
  logic [7:0] io_wdata;
  logic [15:0] io_rdata;
  logic tf_strobe, window_open;
  logic [1:0] addr_setup;
  logic [7:0] rd_active, rd_recover, wr_active, wr_recover;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tfw_window_ctrl uut (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr), .io_word(io_word),
    .io_addr(io_addr), .io_wdata(io_wdata), .bus_clk_25(bus_clk_25),
    .io_rdata(io_rdata), .tf_strobe(tf_strobe), .window_open(window_open),
    .addr_setup(addr_setup), .rd_active(rd_active), .rd_recover(rd_recover),
    .wr_active(wr_active), .wr_recover(wr_recover)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic word, input logic [2:0] a,
                     input logic [7:0] d, output logic [15:0] rd, output logic stb);
    @(negedge clk);
    io_req = 1'b1; io_wr = wr; io_word = word; io_addr = a; io_wdata = d;
    #1;
    rd = io_rdata; stb = tf_strobe;
    @(posedge clk);
    #1;
    io_req = 1'b0;
  endtask

  task automatic wr8(input logic [2:0] a, input logic [7:0] d);
    logic [15:0] r; logic s;
    acc(1'b1, 1'b0, a, d, r, s);
  endtask

  task automatic rd8(input logic [2:0] a, output logic [15:0] r);
    logic s;
    acc(1'b0, 1'b0, a, 8'h00, r, s);
  endtask

  task automatic probe();
    logic [15:0] r; logic s;
    acc(1'b0, 1'b1, 3'd1, 8'h00, r, s);
  endtask

  task automatic unlock();
    probe(); probe(); wr8(3'd2, 8'h03);
  endtask

  logic [7:0] exp_rd [2];
  logic [7:0] exp_wr [2];
  logic [7:0] st_rd [2];
  logic [7:0] st_wr [2];

  task automatic chk_outputs(input string req);
    chk(req, {rd_active, rd_recover},
        {exp_rd[1][7:4], exp_rd[0][7:4], exp_rd[1][3:0], exp_rd[0][3:0]});
    chk(req, {wr_active, wr_recover},
        {exp_wr[1][7:4], exp_wr[0][7:4], exp_wr[1][3:0], exp_wr[0][3:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r; logic s;
    rst_n = 1'b0; io_req = 1'b0; io_wr = 1'b0; io_word = 1'b0;
    io_addr = '0; io_wdata = '0; bus_clk_25 = 1'b0;
    for (int i = 0; i < 2; i++) begin
      exp_rd[i] = 8'hFF; exp_wr[i] = 8'hFF; st_rd[i] = 8'hFF; st_wr[i] = 8'hFF;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state at the ports
    chk("R1 open", window_open, 0);
    chk("R1 setup", addr_setup, 0);
    chk_outputs("R1 outputs");

    // R4 locked accesses go to the task-file
    acc(1'b1, 1'b0, 3'd0, 8'h12, r, s);
    chk("R4 strobe wr", s, 1);
    acc(1'b0, 1'b0, 3'd0, 8'h00, r, s);
    chk("R4 strobe rd", s, 1);
    chk("R4 rdata", r, 0);

    // R2 open
    unlock();
    chk("R2 open", window_open, 1);
    acc(1'b0, 1'b0, 3'd3, 8'h00, r, s);
    chk("R1 ctrl", r, 0);
    chk("R5 no strobe", s, 0);
    rd8(3'd6, r); chk("R1 misc", r, 0);
    rd8(3'd0, r); chk("R4 rd untouched", r, 16'h00FF);
    rd8(3'd1, r); chk("R1 wr timing", r, 16'h00FF);
    rd8(3'd4, r); chk("R5 offset4", r, 0);
    rd8(3'd7, r); chk("R5 offset7", r, 0);

    // R8 strap
    bus_clk_25 = 1'b1; rd8(3'd5, r); chk("R8 strap 25", r, 1);
    bus_clk_25 = 1'b0; rd8(3'd5, r); chk("R8 strap 33", r, 0);
    wr8(3'd5, 8'hFF); rd8(3'd5, r); chk("R8 write ignored", r, 0);

    // R7 misc mask
    wr8(3'd6, 8'hFF); rd8(3'd6, r); chk("R7 misc mask", r, 16'h0031);
    chk("R7 setup", addr_setup, 3);
    chk_outputs("R9 no commit yet");

    // R6 R9 R10 sweep
    for (int dv = 0; dv < 2; dv++) begin
      for (int v = 0; v < 256; v += 15) begin
        logic [7:0] tv, tw; logic [1:0] as;
        tv = 8'(v); tw = 8'(v) ^ 8'hA5; as = 2'(v % 4);
        wr8(3'd6, {2'b00, as, 3'b000, 1'(dv)});
        chk("R7 setup sweep", addr_setup, as);
        wr8(3'd0, tv); wr8(3'd1, tw);
        st_rd[dv] = tv; st_wr[dv] = tw;
        rd8(3'd0, r); chk("R6 rd readback", r, {8'h00, tv});
        rd8(3'd1, r); chk("R6 wr readback", r, {8'h00, tw});
        wr8(3'd6, {2'b00, as, 3'b000, 1'(1 - dv)});
        rd8(3'd0, r); chk("R6 other dev rd", r, {8'h00, st_rd[1-dv]});
        rd8(3'd1, r); chk("R6 other dev wr", r, {8'h00, st_wr[1-dv]});
        wr8(3'd3, 8'h84);
        rd8(3'd3, r); chk("R9 ctrl stored", r, 16'h0084);
        chk_outputs("R9 non-commit");
        wr8(3'd3, 8'h85);
        for (int i = 0; i < 2; i++) begin exp_rd[i] = st_rd[i]; exp_wr[i] = st_wr[i]; end
        chk_outputs("R10 split after commit");
      end
    end

    // R11 close and stay-open
    wr8(3'd2, 8'h84); chk("R11 other key", window_open, 1);
    wr8(3'd2, 8'h83); chk("R11 relock", window_open, 0);
    acc(1'b0, 1'b0, 3'd6, 8'h00, r, s);
    chk("R4 locked misc hidden", r, 0);

    // R3 broken sequences
    probe(); rd8(3'd1, r); probe(); wr8(3'd2, 8'h03);
    chk("R3 byte read break", window_open, 0);
    probe(); wr8(3'd3, 8'h00); probe(); wr8(3'd2, 8'h03);
    chk("R3 other write break", window_open, 0);
    probe(); probe(); acc(1'b1, 1'b1, 3'd2, 8'h03, r, s);
    chk("R3 word key", window_open, 0);
    probe(); probe(); wr8(3'd2, 8'h04);
    chk("R3 wrong key", window_open, 0);
    probe(); probe(); probe(); wr8(3'd2, 8'h03);
    chk("R2 triple read", window_open, 1);
    acc(1'b1, 1'b1, 3'd2, 8'h83, r, s);
    chk("R11 word relock", window_open, 0);
    chk_outputs("R9 outputs held");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule